// File: doc/BRIEF.md
# Receive Bit Error Rate Monitor

This block checks a received payload bit stream against a locally generated reference pattern and counts the bit errors. It is always on, so it can watch live traffic as an off-line monitor. A 32-bit reference shift register is programmed through a length and a tap field. The feedback is either the XOR of two taps, which gives a pseudo-random pattern, or a single tap, which gives a repeating word. The block locks by loading received bits straight into the reference register. After that it confirms the lock by predicting the bits that follow.

Once the block is locked, the reference register free-runs. Each received bit that differs from the predicted bit counts as an error. A sliding 64-bit error history detects loss of lock. A performance-monitor update strobe copies the live bit and error counters into holding outputs and starts a new interval.

Top module: `bert_rx_monitor`

## Requirements
- R1: After reset, `out_of_sync` is 1, `err_present` is 0 and both holding outputs are 0.
- R2: While out of sync, each valid bit is shifted into the reference register. The first 32 bits after a restart are only loaded. Each of the next 32 bits must equal the feedback. A mismatch restarts the sequence, and the mismatching bit counts as the first loaded bit. `out_of_sync` is 0 in the cycle after the 64th consecutive accepted bit.
- R3: The feedback uses bit n = `cfg_len`+1 and bit y = `cfg_tap`+1, with bit 1 the newest. With `cfg_repeat`=0 the feedback is bit n XOR bit y, and it is forced to 1 when bits 1 to 31 are all zero. With `cfg_repeat`=1 the feedback is bit n. While in sync, the reference shifts in its own feedback, and a received bit that differs from the feedback is a bit error.
- R4: While in sync, the block checks the current bit together with the previous 63 in-sync bits. If they hold 6 or more errors, `out_of_sync` becomes 1 in the next cycle and the error history is cleared.
- R5: Every valid bit increments the live bit counter. Only errors on bits received while in sync increment the live error counter.
- R6: A cycle with `pmu_strobe`=1 copies the live counters into `bit_count_hold` and `err_count_hold` and clears them. A valid bit in that same cycle is counted in the new interval.
- R7: Both live counters saturate at 2^CNT_W-1 and do not wrap.
- R8: `err_present` is 1 exactly when the live error counter is nonzero.
- R9: A cycle with `rx_valid`=0 and no strobe leaves the lock state, the counters and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 5 | Main feedback tap position minus one (n-1) |
| cfg_tap | input | 5 | Second feedback tap position minus one (y-1) |
| cfg_repeat | input | 1 | 1: repeating word of length n, 0: pseudo-random |
| rx_bit | input | 1 | Received payload bit |
| rx_valid | input | 1 | rx_bit carries a payload bit this cycle |
| pmu_strobe | input | 1 | Snapshot-and-clear strobe for the counters |
| bit_count_hold | output | CNT_W | Bits received in the last closed interval |
| err_count_hold | output | CNT_W | Bit errors in the last closed interval |
| err_present | output | 1 | Live error counter is nonzero |
| out_of_sync | output | 1 | Reference is not locked to the input |

## Verification
The bench targets these corner cases:

- **Exactly six errors in the window.** Five errors spread over the window must keep the lock, and six inside it must drop it. An off-by-one window or threshold would drop the lock one error early or keep it one error late.
- **Mismatch during the confirm phase.** A bit error here must restart the load. A design that ignored it would declare lock on a wrong seed.
- **Strobe in the same cycle as a valid bit.** The bit must be counted in the new interval, so neither interval gains or loses it.
- **Switch to a repeating word.** This forces lock loss and re-lock.
- **Saturation.** A long run with a narrow counter must stop at the maximum rather than wrap to a small value.

// File: rtl/bert_rx_monitor.sv
module bert_rx_monitor #(
  parameter int CNT_W  = 32,
  parameter int WIN    = 64,
  parameter int THRESH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cfg_len,
  input  logic [4:0]       cfg_tap,
  input  logic             cfg_repeat,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             pmu_strobe,
  output logic [CNT_W-1:0] bit_count_hold,
  output logic [CNT_W-1:0] err_count_hold,
  output logic             err_present,
  output logic             out_of_sync
);
  localparam int REF_W = 32;
  localparam int PH_W  = $clog2(2*REF_W);
  localparam int PW    = $clog2(WIN+1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [REF_W-1:0] ref_q;
  logic [PH_W-1:0]  phase;
  logic [WIN-1:0]   hist;
  logic [PW-1:0]    pop;
  logic [CNT_W-1:0] bit_live, err_live;

  logic fb, mism, err_hit, lose;
  logic [PW:0] pop_nxt;
  logic [CNT_W-1:0] bit_base, err_base, bit_nxt, err_nxt;

  always_comb begin
    fb = cfg_repeat ? ref_q[cfg_len] : (ref_q[cfg_len] ^ ref_q[cfg_tap]);
    if (!cfg_repeat && ref_q[REF_W-2:0] == '0) fb = 1'b1;
  end

  assign mism     = rx_bit ^ fb;
  assign err_hit  = rx_valid && !out_of_sync && mism;
  assign pop_nxt  = {1'b0, pop} + (PW+1)'(mism) - (PW+1)'(hist[WIN-1]);
  assign lose     = err_hit && (pop_nxt >= (PW+1)'(THRESH));
  assign bit_base = pmu_strobe ? '0 : bit_live;
  assign err_base = pmu_strobe ? '0 : err_live;
  assign bit_nxt  = (rx_valid && bit_base != CMAX) ? bit_base + 1'b1 : bit_base;
  assign err_nxt  = (err_hit && err_base != CMAX) ? err_base + 1'b1 : err_base;
  assign err_present = (err_live != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q          <= '0;
      phase          <= '0;
      hist           <= '0;
      pop            <= '0;
      out_of_sync    <= 1'b1;
      bit_live       <= '0;
      err_live       <= '0;
      bit_count_hold <= '0;
      err_count_hold <= '0;
    end else begin
      bit_live <= bit_nxt;
      err_live <= err_nxt;
      if (pmu_strobe) begin
        bit_count_hold <= bit_live;
        err_count_hold <= err_live;
      end
      if (rx_valid) begin
        if (out_of_sync) begin
          ref_q <= {ref_q[REF_W-2:0], rx_bit};
          if (phase < PH_W'(REF_W)) phase <= phase + 1'b1;
          else if (mism) phase <= PH_W'(1);
          else if (phase == '1) begin
            phase       <= '0;
            out_of_sync <= 1'b0;
          end else phase <= phase + 1'b1;
        end else begin
          ref_q <= {ref_q[REF_W-2:0], fb};
          if (lose) begin
            hist        <= '0;
            pop         <= '0;
            phase       <= '0;
            out_of_sync <= 1'b1;
          end else begin
            hist <= {hist[WIN-2:0], mism};
            pop  <= pop_nxt[PW-1:0];
          end
        end
      end
    end
  end

  // R2
  restart_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_sync && rx_valid && phase >= PH_W'(REF_W) && mism |=> phase == PH_W'(1) && out_of_sync);
  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop < PW'(THRESH));
  // R5
  no_err_oos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_sync && !pmu_strobe |=> $stable(err_live));
  // R6
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_strobe |=> bit_count_hold == $past(bit_live) && err_count_hold == $past(err_live));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_strobe && !rx_valid |=> !err_present);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_live == CMAX && rx_valid && !pmu_strobe |=> bit_live == CMAX);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid && !pmu_strobe |=> $stable(bit_live) && $stable(out_of_sync) && $stable(err_live));
endmodule

// File: tb/bert_rx_monitor_test.sv
module bert_rx_monitor_test;
  localparam int CLK_P = 10;
  localparam int CW = 10;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 0, rst_n = 0;
  logic [4:0] cfg_len = 5'd14, cfg_tap = 5'd13;
  logic cfg_repeat = 0, rx_bit = 0, rx_valid = 0, pmu_strobe = 0;
  logic [CW-1:0] bit_count_hold, err_count_hold;
  logic err_present, out_of_sync;

  bert_rx_monitor #(.CNT_W(CW)) uut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] tx = 32'h1;
  logic [31:0] m_ref;
  logic [63:0] m_hist;
  int m_ph;
  logic m_oos;
  logic [CW-1:0] m_bits, m_errs, m_hb, m_he;

  function automatic logic fbf(input logic [31:0] r);
    logic f;
    if (cfg_repeat) return r[cfg_len];
    f = r[cfg_len] ^ r[cfg_tap];
    if (r[30:0] == 0) f = 1'b1;
    return f;
  endfunction

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] x);
    return (x == CMAX) ? x : x + 1'b1;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ref = 0; m_hist = 0; m_ph = 0; m_oos = 1;
    m_bits = 0; m_errs = 0; m_hb = 0; m_he = 0;
  endtask

  task automatic step(input logic b, input logic v, input logic p);
    logic f;
    @(negedge clk);
    rx_bit = b; rx_valid = v; pmu_strobe = p;
    f = fbf(m_ref);
    if (p) begin m_hb = m_bits; m_he = m_errs; m_bits = 0; m_errs = 0; end
    if (v) begin
      m_bits = inc(m_bits);
      if (m_oos) begin
        m_ref = {m_ref[30:0], b};
        if (m_ph < 32) m_ph++;
        else if (b != f) m_ph = 1;
        else if (m_ph == 63) begin m_ph = 0; m_oos = 0; end
        else m_ph++;
      end else begin
        m_ref = {m_ref[30:0], f};
        if (b != f) m_errs = inc(m_errs);
        m_hist = {m_hist[62:0], b != f};
        if ((b != f) && $countones(m_hist) >= 6) begin
          m_oos = 1; m_hist = 0; m_ph = 0;
        end
      end
    end
    @(posedge clk); #1;
    rx_valid = 0; pmu_strobe = 0;
    chk("R2 R4 out_of_sync", out_of_sync, m_oos);
    chk("R8 err_present", err_present, m_errs != 0);
    chk("R6 bit_count_hold", bit_count_hold, m_hb);
    chk("R5 R6 err_count_hold", err_count_hold, m_he);
  endtask

  task automatic send(input logic inj, input logic p);
    logic o;
    o = fbf(tx);
    tx = {tx[30:0], o};
    step(o ^ inj, 1'b1, p);
  endtask

  task automatic idle(input logic p);
    step(1'($urandom), 1'b0, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hang expected finish");
    if (!done) begin done = 1; $display("%0d/%0d checks passed", checks - fails, checks); end
    $finish;
  end

  initial begin
    void'($urandom(1234));
    model_reset();
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1 oos", out_of_sync, 1); chk("R1 flag", err_present, 0);
    chk("R1 bhold", bit_count_hold, 0); chk("R1 ehold", err_count_hold, 0);
    rst_n = 1;

    // R2: clean lock, exactly 64 bits
    for (int i = 0; i < 63; i++) send(0, 0);
    chk("R2 still oos at 63", out_of_sync, 1);
    send(0, 0);
    chk("R2 lock at 64", out_of_sync, 0);
    send(0, 1);
    chk("R6 R5 hold bits 64", bit_count_hold, 64);
    chk("R5 no oos errors", err_count_hold, 0);

    // R4: five spread errors keep lock
    for (int i = 0; i < 5; i++) begin send(1, 0); repeat (10) send(0, 0); end
    chk("R4 five keep", out_of_sync, 0);
    // R4: sixth within window drops
    send(1, 0);
    chk("R4 six drops", out_of_sync, 1);

    // R2: mismatch in confirm phase restarts
    for (int i = 0; i < 40; i++) send(0, 0);
    send(1, 0);
    for (int i = 0; i < 62; i++) send(0, 0);
    chk("R2 restart not locked", out_of_sync, 1);
    send(0, 0);
    chk("R2 relock after restart", out_of_sync, 0);

    // R9 idle cycles
    repeat (20) idle(0);
    chk("R9 idle keeps lock", out_of_sync, 0);
    // R6 strobe with bit same cycle, then strobe idle
    send(0, 1); idle(1);
    chk("R6 new interval holds 1", bit_count_hold, 1);
    chk("R8 flag cleared", err_present, 0);

    // Random traffic with sparse errors
    for (int i = 0; i < 20000; i++) begin
      logic inj, p;
      inj = ($urandom % 150) == 0;
      p = ($urandom % 97) == 0;
      if (($urandom % 6) == 0) idle(p); else send(inj, p);
    end
    // Error bursts force losses
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < 8; i++) send(1, 0);
      for (int i = 0; i < 200; i++) send(($urandom % 40) == 0, ($urandom % 50) == 0);
    end

    // R3: repeating word of length 8
    cfg_repeat = 1; cfg_len = 5'd7;
    tx = {4{8'h27}};
    for (int i = 0; i < 300; i++) send(0, 0);
    chk("R3 repeat lock", out_of_sync, 0);
    send(0, 1);
    for (int i = 0; i < 100; i++) send(i % 30 == 0, 0);
    send(0, 1);
    chk("R3 R5 repeat errors", err_count_hold, 4);

    // R3 PRBS 2^9-1 (n=9, y=5)
    cfg_repeat = 0; cfg_len = 5'd8; cfg_tap = 5'd4; tx = 32'h5A;
    for (int i = 0; i < 300; i++) send(0, 0);
    chk("R3 prbs9 lock", out_of_sync, 0);

    // R7 saturation
    send(0, 1);
    for (int i = 0; i < 1100; i++) send(i % 20 == 0, 0);
    send(0, 1);
    chk("R7 bits saturate", bit_count_hold, CMAX);

    if (!done) begin done = 1; $display("%0d/%0d checks passed", checks - fails, checks); end
    $finish;
  end
endmodule